// File: doc/BRIEF.md
# Banked Interrupt Controller Register File

This block gathers forty level-sensitive interrupt inputs into two 32-bit banks and presents them on a word-addressed 32-bit register bus. Source n lives in bank 0 when n is below 32 and in bank 1 otherwise, at bit n mod 32. Each source has an enable bit and a routing bit. The routing bit sends an enabled, active source either to the fast interrupt line or to the normal interrupt line. A control bit sets whether a halted processor may be woken by any active source or only by enabled ones.

A pending bit is the live level of its input pin. No latch holds it and software cannot clear it. The two interrupt lines are registered. A separate block computes the highest-priority encoding, and that value is only routed onto the read bus here. Forty priority-slot registers hold a valid flag and a source number for that separate block.

Top module: `banked_intc`

## Requirements
- R1: Source n maps to bank (n >= 32) at bit n mod 32. Bank 1 registers hold bits for sources 32..39 in bits 7:0, and their bits 31:8 always read as zero.
- R2: Raw pending (bank 0 at 0x10, bank 1 at 0xAC) reads the present input levels. A bit reads 1 while its input is high and 0 once the input is low.
- R3: Normal-pending (0x00 / 0x9C) reads pending AND enable AND NOT routing. Fast-pending (0x0C / 0xA8) reads pending AND enable AND routing.
- R4: `irqOut` is high one clock after any enabled, active source with routing bit 0 exists in either bank, and low one clock after none exists.
- R5: `fiqOut` is high one clock after any enabled, active source with routing bit 1 exists in either bank, and low one clock after none exists.
- R6: `wakeOut` is low while `halted` is low. While `halted` is high it is the OR over both banks of pending AND (enable OR all-ones when control bit 0 is 0, enable alone when control bit 0 is 1).
- R7: Enable (0x04 / 0xA0), routing (0x08 / 0xA4) and control bit 0 (0x14) read back what was written. Control bits 31:1 read 0.
- R8: Priority slot i sits at 0x1C+4i for i < 32 and at 0xB0+4(i-32) for i >= 32. It keeps only bit 31 and bits 5:0 of a write, and every other bit reads 0.
- R9: A read of 0x18 returns the `prioCode` input unchanged.
- R10: Writes to the pending offsets, to 0x18 and to unmapped or misaligned offsets change no register. Reads of unmapped offsets return 0.
- R11: Reset clears enable, routing, control and every priority slot, and drives `irqOut` and `fiqOut` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcLevel | input | 40 | Interrupt source levels |
| halted | input | 1 | Processor is halted |
| busValid | input | 1 | Bus access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address, word aligned |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational, 0 when no read is active |
| prioCode | input | 32 | Highest-priority encoding from the external encoder |
| irqOut | output | 1 | Normal interrupt request, registered |
| fiqOut | output | 1 | Fast interrupt request, registered |
| wakeOut | output | 1 | Wake request for a halted processor |

## Verification
Sources are raised in both banks at once (sources 0, 2 and 39), so a bank-indexing fault shows up as a wrong bit in one of the two raw, normal or fast views. The enable and routing patterns then move one active source from the normal line to the fast line and mask another. This separates an inverted routing term from a missing enable term, and it shows whether the interrupt lines are the OR over both banks. A single-step level change checks the one-clock output latency. Wake is tried with the processor running and halted, and with the control bit both clear and set, using a masked source in bank 1.

// File: rtl/banked_intc_pkg.sv
package banked_intc_pkg;
  localparam int NUM_SRC   = 40;
  localparam int BANK_W    = 32;
  localparam int NUM_BANKS = (NUM_SRC + BANK_W - 1) / BANK_W;
  localparam int SLOT_ID_W = 6;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 32;

  typedef enum logic [3:0] {
    K_NONE, K_IRQ_PEND, K_MASK, K_STEER, K_FIQ_PEND,
    K_RAW, K_CTRL, K_HIGHEST, K_SLOT
  } regKind_e;

  typedef struct packed {
    logic                 rdEn;
    logic                 wrEn;
    regKind_e             kind;
    logic                 bankSel;
    logic [SLOT_ID_W-1:0] slotIdx;
  } busStrobe_t;
endpackage

// File: rtl/banked_intc_ctrl.sv
module banked_intc_ctrl
  import banked_intc_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          busValid,
  input  logic          busWrite,
  input  logic [AW-1:0] busAddr,
  output busStrobe_t    strobe
);
  localparam int WORD_W   = AW - 2;
  localparam int SLOT_LO0 = 7;   // first low-slot word
  localparam int BANK1_W0 = 39;  // first bank-1 word
  localparam int SLOT_HI0 = 44;  // first high-slot word
  localparam int SLOT_HI1 = SLOT_HI0 + (NUM_SRC - BANK_W) - 1;

  logic [WORD_W-1:0] wordIdx;
  regKind_e          kindDec;
  logic              bankDec;
  logic [SLOT_ID_W-1:0] slotDec;
  logic              writable;

  assign wordIdx = busAddr[AW-1:2];

  function automatic regKind_e bankKind(input int off);
    case (off)
      0:       return K_IRQ_PEND;
      1:       return K_MASK;
      2:       return K_STEER;
      3:       return K_FIQ_PEND;
      4:       return K_RAW;
      default: return K_NONE;
    endcase
  endfunction

  always_comb begin
    kindDec = K_NONE;
    bankDec = 1'b0;
    slotDec = '0;
    if (busAddr[1:0] == 2'b00) begin
      if (int'(wordIdx) <= 4) begin
        kindDec = bankKind(int'(wordIdx));
      end else if (int'(wordIdx) == 5) begin
        kindDec = K_CTRL;
      end else if (int'(wordIdx) == 6) begin
        kindDec = K_HIGHEST;
      end else if (int'(wordIdx) < SLOT_LO0 + BANK_W) begin
        kindDec = K_SLOT;
        slotDec = SLOT_ID_W'(int'(wordIdx) - SLOT_LO0);
      end else if (int'(wordIdx) < BANK1_W0 + 5) begin
        kindDec = bankKind(int'(wordIdx) - BANK1_W0);
        bankDec = 1'b1;
      end else if (int'(wordIdx) <= SLOT_HI1) begin
        kindDec = K_SLOT;
        slotDec = SLOT_ID_W'(BANK_W + int'(wordIdx) - SLOT_HI0);
      end
    end
  end

  always_comb begin
    case (kindDec)
      K_MASK, K_STEER, K_CTRL, K_SLOT: writable = 1'b1;
      default:                         writable = 1'b0;
    endcase
  end

  assign strobe.rdEn    = busValid & ~busWrite;
  assign strobe.wrEn    = busValid & busWrite & writable;
  assign strobe.kind    = kindDec;
  assign strobe.bankSel = bankDec;
  assign strobe.slotIdx = slotDec;

  always_comb begin
    // R10: a read-only or unmapped offset never yields a write strobe
    AST_RO_NO_STROBE: assert (!(strobe.wrEn && (kindDec == K_NONE || kindDec == K_RAW ||
                                kindDec == K_HIGHEST || kindDec == K_IRQ_PEND ||
                                kindDec == K_FIQ_PEND))); // R10
  end
endmodule

// File: rtl/banked_intc_dp.sv
module banked_intc_dp
  import banked_intc_pkg::*;
#(
  parameter int NSRC = NUM_SRC,
  parameter int BW   = BANK_W,
  parameter int DW   = DATA_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] srcLevel,
  input  logic            halted,
  input  busStrobe_t      strobe,
  input  logic [DW-1:0]   busWdata,
  input  logic [DW-1:0]   prioCode,
  output logic [DW-1:0]   busRdata,
  output logic            irqOut,
  output logic            fiqOut,
  output logic            wakeOut
);
  localparam int NB    = (NSRC + BW - 1) / BW;
  localparam int PAD_W = NB * BW;
  localparam int VALID_BIT = DW - 1;

  logic [NSRC-1:0] maskR, steerR;
  logic            ctrlR;
  logic [NSRC-1:0] liveMasked, irqVec, fiqVec, wakeVec;
  logic [DW-1:0]   slotRd [NSRC];

  assign liveMasked = srcLevel & maskR;
  assign irqVec     = liveMasked & ~steerR;
  assign fiqVec     = liveMasked & steerR;
  assign wakeVec    = srcLevel & (maskR | {NSRC{~ctrlR}});

  // per-source enable and routing bits
  for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
    localparam int BANK = gi / BW;
    localparam int POS  = gi % BW;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskR[gi]  <= 1'b0;
        steerR[gi] <= 1'b0;
      end else if (strobe.wrEn && int'(strobe.bankSel) == BANK) begin
        if (strobe.kind == K_MASK)  maskR[gi]  <= busWdata[POS];
        if (strobe.kind == K_STEER) steerR[gi] <= busWdata[POS];
      end
    end
  end

  // priority slots: valid flag and source number only
  for (genvar gs = 0; gs < NSRC; gs++) begin : g_slot
    logic                 slotValid;
    logic [SLOT_ID_W-1:0] slotId;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotValid <= 1'b0;
        slotId    <= '0;
      end else if (strobe.wrEn && strobe.kind == K_SLOT && int'(strobe.slotIdx) == gs) begin
        slotValid <= busWdata[VALID_BIT];
        slotId    <= busWdata[SLOT_ID_W-1:0];
      end
    end
    assign slotRd[gs] = {slotValid, {(DW-1-SLOT_ID_W){1'b0}}, slotId};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlR  <= 1'b0;
      irqOut <= 1'b0;
      fiqOut <= 1'b0;
    end else begin
      if (strobe.wrEn && strobe.kind == K_CTRL) ctrlR <= busWdata[0];
      irqOut <= |irqVec;
      fiqOut <= |fiqVec;
    end
  end

  assign wakeOut = halted & (|wakeVec);

  function automatic logic [DW-1:0] bankOf(input logic [NSRC-1:0] vec, input logic sel);
    logic [PAD_W-1:0] padded;
    padded = PAD_W'(vec);
    return DW'(padded[int'(sel)*BW +: BW]);
  endfunction

  always_comb begin
    busRdata = '0;
    if (strobe.rdEn) begin
      case (strobe.kind)
        K_IRQ_PEND: busRdata = bankOf(irqVec, strobe.bankSel);
        K_FIQ_PEND: busRdata = bankOf(fiqVec, strobe.bankSel);
        K_RAW:      busRdata = bankOf(srcLevel, strobe.bankSel);
        K_MASK:     busRdata = bankOf(maskR, strobe.bankSel);
        K_STEER:    busRdata = bankOf(steerR, strobe.bankSel);
        K_CTRL:     busRdata = DW'(ctrlR);
        K_HIGHEST:  busRdata = prioCode;
        K_SLOT:     busRdata = slotRd[strobe.slotIdx];
        default:    busRdata = '0;
      endcase
    end
  end

  AST_WAKE_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rstN)
    !halted |-> !wakeOut); // R6
  AST_FIQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    fiqOut |-> $past(|srcLevel)); // R5
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(|maskR)); // R4
  AST_STEER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrEn && strobe.kind == K_STEER) |=> $stable(steerR)); // R10
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrEn && strobe.kind == K_MASK) |=> $stable(maskR)); // R10
  AST_SLOT_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && strobe.kind == K_SLOT) |-> (busRdata[DW-2:SLOT_ID_W] == '0)); // R8
endmodule

// File: rtl/banked_intc.sv
module banked_intc
  import banked_intc_pkg::*;
#(
  parameter int NSRC = NUM_SRC,
  parameter int AW   = ADDR_W,
  parameter int DW   = DATA_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] srcLevel,
  input  logic            halted,
  input  logic            busValid,
  input  logic            busWrite,
  input  logic [AW-1:0]   busAddr,
  input  logic [DW-1:0]   busWdata,
  output logic [DW-1:0]   busRdata,
  input  logic [DW-1:0]   prioCode,
  output logic            irqOut,
  output logic            fiqOut,
  output logic            wakeOut
);
  busStrobe_t strobe;

  banked_intc_ctrl #(.AW(AW)) u_ctrl (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobe   (strobe)
  );

  banked_intc_dp #(.NSRC(NSRC), .BW(BANK_W), .DW(DW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .srcLevel (srcLevel),
    .halted   (halted),
    .strobe   (strobe),
    .busWdata (busWdata),
    .prioCode (prioCode),
    .busRdata (busRdata),
    .irqOut   (irqOut),
    .fiqOut   (fiqOut),
    .wakeOut  (wakeOut)
  );
endmodule

// File: tb/banked_intc_tb.sv
`timescale 1ns/1ps
module banked_intc_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [39:0] srcLevel = '0;
  logic        halted = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] prioCode = '0;
  logic        irqOut, fiqOut, wakeOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];
  bit          rdPend = 1'b0;

  always #2.5 clk = ~clk;

  banked_intc u_dut (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .halted(halted),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .prioCode(prioCode),
    .irqOut(irqOut), .fiqOut(fiqOut), .wakeOut(wakeOut)
  );

  // monitor: pops the expected read and compares
  always @(negedge clk) begin
    if (rdPend) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (busRdata !== e) begin
        failures++;
        $display("FAIL %s: read 0x%08h expected 0x%08h", t, busRdata, e);
      end
      rdPend = 1'b0;
    end
  end

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    expQ.push_back(e); tagQ.push_back(t); rdPend = 1'b1;
    @(posedge clk); #1;
    busValid = 1'b0;
  endtask

  task automatic chkBit(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      failures++;
      $display("FAIL %s: got %0b expected %0b", t, act, e);
    end
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R11 reset state
    @(negedge clk);
    chkBit(irqOut, 1'b0, "R11 irqOut after reset");
    chkBit(fiqOut, 1'b0, "R11 fiqOut after reset");
    busRd(8'h04, 32'h0, "R11 enable bank0 reset");
    busRd(8'h08, 32'h0, "R11 routing bank0 reset");
    busRd(8'h14, 32'h0, "R11 control reset");

    // R1 R2 bank mapping of raw levels: sources 0, 2, 39
    srcLevel = 40'h80_0000_0005;
    busRd(8'h10, 32'h0000_0005, "R2 raw bank0");
    busRd(8'hAC, 32'h0000_0080, "R1 raw bank1 source 39 at bit 7");
    settle();
    chkBit(irqOut, 1'b0, "R4 no irq while disabled");

    // R7 R1 enable write/readback, bank1 upper bits dropped
    busWr(8'h04, 32'hFFFF_FFFF);
    busWr(8'hA0, 32'hFFFF_FFFF);
    busRd(8'h04, 32'hFFFF_FFFF, "R7 enable bank0 readback");
    busRd(8'hA0, 32'h0000_00FF, "R1 enable bank1 bits 31:8 zero");
    busRd(8'h00, 32'h0000_0005, "R3 normal pending bank0");
    busRd(8'h9C, 32'h0000_0080, "R3 normal pending bank1");
    settle();
    chkBit(irqOut, 1'b1, "R4 irq with enabled sources");
    chkBit(fiqOut, 1'b0, "R5 no fiq without routing");

    // route source 2 to fast, source 39 to fast, then disable source 0
    busWr(8'h08, 32'h0000_0004);
    busWr(8'hA4, 32'h0000_0080);
    busRd(8'h08, 32'h0000_0004, "R7 routing bank0 readback");
    busRd(8'h00, 32'h0000_0001, "R3 normal pending after routing");
    busRd(8'h0C, 32'h0000_0004, "R3 fast pending bank0");
    busRd(8'hA8, 32'h0000_0080, "R3 fast pending bank1");
    settle();
    chkBit(fiqOut, 1'b1, "R5 fiq with routed source");
    chkBit(irqOut, 1'b1, "R4 irq from source 0");
    busWr(8'h04, 32'h0000_0004);
    busRd(8'h00, 32'h0000_0000, "R3 normal pending masked");
    settle();
    chkBit(irqOut, 1'b0, "R4 irq low when only fast sources remain");
    chkBit(fiqOut, 1'b1, "R5 fiq stays high");

    // R2 level follows input, no latch; R5 drops with level
    srcLevel = '0;
    busRd(8'h10, 32'h0, "R2 raw clears when input low");
    settle();
    chkBit(fiqOut, 1'b0, "R5 fiq low after input low");

    // R4 one-clock latency
    busWr(8'h08, 32'h0);
    settle();
    @(posedge clk); #1 srcLevel = 40'h4;
    @(negedge clk);
    chkBit(irqOut, 1'b0, "R4 irq not yet updated same cycle");
    @(negedge clk);
    chkBit(irqOut, 1'b1, "R4 irq updated one clock later");

    // R6 wake
    busWr(8'h04, 32'h0);
    busWr(8'hA0, 32'h0);
    srcLevel = 40'h02_0000_0000; // source 33
    halted = 1'b0;
    @(negedge clk);
    chkBit(wakeOut, 1'b0, "R6 no wake while running");
    halted = 1'b1;
    @(negedge clk);
    chkBit(wakeOut, 1'b1, "R6 wake from masked source when control 0");
    busWr(8'h14, 32'hFFFF_FFFF);
    busRd(8'h14, 32'h0000_0001, "R7 control reads 1");
    @(negedge clk);
    chkBit(wakeOut, 1'b0, "R6 masked source no wake when control 1");
    busWr(8'hA0, 32'h0000_0002);
    @(negedge clk);
    chkBit(wakeOut, 1'b1, "R6 enabled source wakes when control 1");
    halted = 1'b0;

    // R8 priority slots
    busWr(8'h1C, 32'hFFFF_FFFF);
    busWr(8'hCC, 32'h1234_5678);
    busWr(8'hB0, 32'h8000_0027);
    busRd(8'h1C, 32'h8000_003F, "R8 slot 0 keeps bit31 and 5:0");
    busRd(8'hCC, 32'h0000_0038, "R8 slot 39");
    busRd(8'hB0, 32'h8000_0027, "R8 slot 32");
    busRd(8'h98, 32'h0000_0000, "R8 slot 31 untouched");

    // R9 highest-priority passthrough
    prioCode = 32'hDEAD_BEEF;
    busRd(8'h18, 32'hDEAD_BEEF, "R9 highest-priority read");

    // R10 ignored writes
    busWr(8'h00, 32'hFFFF_FFFF);
    busWr(8'h0C, 32'hFFFF_FFFF);
    busWr(8'h10, 32'hFFFF_FFFF);
    busWr(8'h18, 32'hFFFF_FFFF);
    busWr(8'hD0, 32'hFFFF_FFFF);
    busWr(8'h06, 32'hFFFF_FFFF);
    busRd(8'h04, 32'h0000_0000, "R10 enable bank0 unchanged");
    busRd(8'h08, 32'h0000_0000, "R10 routing bank0 unchanged");
    busRd(8'h14, 32'h0000_0001, "R10 control unchanged");
    busRd(8'h10, 32'h0000_0000, "R10 raw still follows input");
    busRd(8'hD0, 32'h0000_0000, "R10 unmapped read zero");
    busRd(8'hFC, 32'h0000_0000, "R10 unmapped high read zero");

    // R11 reset mid-run
    @(posedge clk); #1 rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    busRd(8'hA0, 32'h0, "R11 enable bank1 cleared");
    busRd(8'h14, 32'h0, "R11 control cleared");
    busRd(8'h1C, 32'h0, "R11 slot 0 cleared");

    repeat (2) @(posedge clk);
    finishRun();
  end
endmodule